// File: doc/BRIEF.md
# Pulse-Count Single-Wire Register Writer

This block takes one write-only control line and turns it into register writes. The sender encodes each value as a burst of low pulses. A burst of n low pulses carries the value n-1. A high hold on the line closes each burst. The block samples the line with a free-running clock and measures every threshold as a number of clock cycles.

Transfers come in pairs. The first burst gives the target address and the second gives the data. After each data burst the block waits for an address again. Other hold lengths have their own effects:
- a long high turns the interface on from the disabled state;
- a longer high parks the interface in standby;
- a still longer high clears a rejected address;
- a long low shuts the interface down and wipes the registers.

Accepted writes come out as a one-cycle strobe with the address and the data. A six-entry register file of 6-bit registers stores the writes aimed at the lowest six addresses.

Top module: `pcw_writer`

## Requirements
- R1: After reset, `dev_en_o`, `wr_stb_o`, `standby_o` and `regs_clr_o` are low and all register contents on `regs_o` are zero.
- R2: While disabled, the block enables once the line stays high for at least `T_EN` cycles. Pulses shorter than that, seen while disabled, produce no enable and no write.
- R3: A burst of n low pulses (n counts falling edges) encodes the value n-1. A high hold of at least `T_HOLD` cycles latches a value of 0 to 31 as the address. A hold that follows no pulse at all has no effect.
- R4: The burst after a latched address is data. If its value is 0 to 63, a hold of at least `T_HOLD` gives exactly one cycle of `wr_stb_o` with that address and data. The next burst is then an address again.
- R5: High gaps shorter than `T_HOLD` inside a burst do not end it. Pulses keep adding to the same count.
- R6: If the line stays high for `T_HOLDA_MAX` cycles after an address is latched and before any data pulse, the address is dropped. The next burst is taken as an address.
- R7: An address value above 31 is rejected. Further bursts are ignored until the line stays high for `T_BR` cycles, after which an address is expected.
- R8: A data value above 63 gives no strobe. The next burst is taken as an address.
- R9: `standby_o` is high while the block is enabled, the line has been high for at least `T_STBY` cycles, and no rejected address is pending.
- R10: While enabled, a low of at least `T_SD` cycles disables the block. It also gives a one-cycle `regs_clr_o` and zeroes every register.
- R11: A strobe with an address below 6 stores the data in `regs_o[addr*6 +: 6]`. Strobes to addresses 6 to 31 still appear on the port but change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Asynchronous single-wire control line |
| dev_en_o | output | 1 | Interface enabled |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 5 | Address of the current write |
| wr_data_o | output | 6 | Data of the current write |
| standby_o | output | 1 | Line idle high long enough for standby |
| regs_clr_o | output | 1 | One-cycle pulse when shutdown clears the registers |
| regs_o | output | 36 | Six 6-bit registers, entry k at bits k*6+5..k*6 |

## Verification
The bench scales all thresholds down to a few tens of cycles:
- `T_EN`=40 and `T_HOLD`=20;
- `T_HOLDA_MAX`=60 and `T_STBY`=100;
- `T_SD`=120 and `T_BR`=150.

With these values, the enable, standby, bus-reset and shutdown windows are all reached within a short run. The address and data widths stay at 5 and 6 bits. Because of that, the overflow cases use real bursts of 33 and 65 pulses: a value of 32 for the address and 64 for the data. Those bursts exercise the count saturation and the range limits exactly at their boundaries.

// File: rtl/pcw_pkg.sv
// Shared types for the pulse-count single-wire writer.
package pcw_pkg;
    // Decoder phase: which kind of burst is expected next.
    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_DATA = 2'd1,
        PH_LOCK = 2'd2
    } phase_e;
endpackage

// File: rtl/pcw_sync.sv
// Multi-flop synchronizer for one asynchronous input.
// Assumes STAGES >= 2; the output resets low.
module pcw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d_i};
    end

    assign q_o = sh[STAGES-1];
endmodule

// File: rtl/pcw_decoder.sv
// Pulse-count decoder. It counts falling edges of the synchronized line,
// measures high and low run lengths in clock cycles, and turns the hold
// windows into address latches, write strobes, bus resets, standby and
// shutdown.
// Assumes T_HOLD < T_HOLDA_MAX < T_STBY < T_BR, and T_EN, T_SD > T_HOLD.
module pcw_decoder
    import pcw_pkg::*;
#(
    parameter int AW          = 5,
    parameter int DW          = 6,
    parameter int T_EN        = 125000,
    parameter int T_SD        = 1250000,
    parameter int T_HOLD      = 68750,
    parameter int T_HOLDA_MAX = 625000,
    parameter int T_STBY      = 1250000,
    parameter int T_BR        = 1500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ln_i,
    output logic          en_o,
    output logic          stb_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          standby_o,
    output logic          clr_o
);
    localparam int ADDR_MAX = (1 << AW) - 1;
    localparam int DATA_MAX = (1 << DW) - 1;
    localparam int CNT_SAT  = DATA_MAX + 2;
    localparam int CW       = $clog2(CNT_SAT + 1);
    localparam int TSUM     = T_EN + T_SD + T_STBY + T_BR;
    localparam int TW       = $clog2(TSUM + 1);

    logic          ln_q;
    logic [TW-1:0] hcnt, lcnt;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;
    phase_e        phase;
    logic          fall;

    assign fall = ln_q & ~ln_i;

    // Measure the current high run and low run, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= 1'b0;
            hcnt <= '0;
            lcnt <= '0;
        end else begin
            ln_q <= ln_i;
            hcnt <= ln_i ? ((hcnt == TW'(TSUM)) ? hcnt : hcnt + 1'b1) : '0;
            lcnt <= ln_i ? '0 : ((lcnt == TW'(TSUM)) ? lcnt : lcnt + 1'b1);
        end
    end

    // Protocol state: enable, pulse count, phase and write outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            stb_o  <= 1'b0;
            clr_o  <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
            addr_q <= '0;
            cnt    <= '0;
            phase  <= PH_ADDR;
        end else begin
            stb_o <= 1'b0;
            clr_o <= 1'b0;
            if (!en_o) begin
                if (ln_i && hcnt == TW'(T_EN)) begin
                    en_o  <= 1'b1;
                    phase <= PH_ADDR;
                    cnt   <= '0;
                end
            end else if (!ln_i && lcnt == TW'(T_SD)) begin
                en_o  <= 1'b0;
                clr_o <= 1'b1;
                phase <= PH_ADDR;
                cnt   <= '0;
            end else begin
                if (fall && phase != PH_LOCK && cnt != CW'(CNT_SAT))
                    cnt <= cnt + 1'b1;
                if (ln_i && hcnt == TW'(T_HOLD) && cnt != '0 && phase != PH_LOCK) begin
                    cnt <= '0;
                    if (phase == PH_ADDR) begin
                        if (cnt <= CW'(ADDR_MAX + 1)) begin
                            addr_q <= AW'(cnt - 1'b1);
                            phase  <= PH_DATA;
                        end else begin
                            phase  <= PH_LOCK;
                        end
                    end else begin
                        if (cnt <= CW'(DATA_MAX + 1)) begin
                            stb_o  <= 1'b1;
                            addr_o <= addr_q;
                            data_o <= DW'(cnt - 1'b1);
                        end
                        phase <= PH_ADDR;
                    end
                end
                if (ln_i && hcnt == TW'(T_HOLDA_MAX) && phase == PH_DATA && cnt == '0)
                    phase <= PH_ADDR;
                if (ln_i && hcnt == TW'(T_STBY) && phase != PH_LOCK) begin
                    phase <= PH_ADDR;
                    cnt   <= '0;
                end
                if (ln_i && hcnt == TW'(T_BR) && phase == PH_LOCK) begin
                    phase <= PH_ADDR;
                    cnt   <= '0;
                end
            end
        end
    end

    assign standby_o = en_o && ln_i && (hcnt >= TW'(T_STBY)) && (phase != PH_LOCK);
endmodule

// File: rtl/pcw_regfile.sv
// Write-only register file. It stores strobed data at addresses below
// NREG, ignores higher addresses, and clears on a clear pulse.
// Assumes NREG <= 2**AW.
module pcw_regfile #(
    parameter int AW   = 5,
    parameter int DW   = 6,
    parameter int NREG = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               we_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [DW-1:0]      data_i,
    output logic [NREG*DW-1:0] regs_o
);
    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic [DW-1:0] r;
        // Hold one entry; a clear wins over a write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)                      r <= '0;
            else if (we_i && addr_i == AW'(k))        r <= data_i;
        end
        assign regs_o[k*DW +: DW] = r;
    end
endmodule

// File: rtl/pcw_writer.sv
// Top of the pulse-count single-wire register writer: synchronizer,
// decoder and register file. All thresholds are counted in cycles of clk.
module pcw_writer #(
    parameter int AW          = 5,
    parameter int DW          = 6,
    parameter int NREG        = 6,
    parameter int SYNC_STAGES = 2,
    parameter int T_EN        = 125000,
    parameter int T_SD        = 1250000,
    parameter int T_HOLD      = 68750,
    parameter int T_HOLDA_MAX = 625000,
    parameter int T_STBY      = 1250000,
    parameter int T_BR        = 1500000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_i,
    output logic               dev_en_o,
    output logic               wr_stb_o,
    output logic [AW-1:0]      wr_addr_o,
    output logic [DW-1:0]      wr_data_o,
    output logic               standby_o,
    output logic               regs_clr_o,
    output logic [NREG*DW-1:0] regs_o
);
    logic ln;

    pcw_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(ln)
    );

    pcw_decoder #(
        .AW(AW), .DW(DW), .T_EN(T_EN), .T_SD(T_SD), .T_HOLD(T_HOLD),
        .T_HOLDA_MAX(T_HOLDA_MAX), .T_STBY(T_STBY), .T_BR(T_BR)
    ) dec_i (
        .clk(clk), .rst_n(rst_n), .ln_i(ln), .en_o(dev_en_o),
        .stb_o(wr_stb_o), .addr_o(wr_addr_o), .data_o(wr_data_o),
        .standby_o(standby_o), .clr_o(regs_clr_o)
    );

    pcw_regfile #(.AW(AW), .DW(DW), .NREG(NREG)) rf_i (
        .clk(clk), .rst_n(rst_n), .clr_i(regs_clr_o), .we_i(wr_stb_o),
        .addr_i(wr_addr_o), .data_i(wr_data_o), .regs_o(regs_o)
    );
endmodule

// File: rtl/pcw_writer_chk.sv
// Property checker for pcw_writer, bound to every instance of the top.
module pcw_writer_chk #(
    parameter int AW   = 5,
    parameter int DW   = 6,
    parameter int NREG = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dev_en,
    input logic               wr_stb,
    input logic [AW-1:0]      wr_addr,
    input logic [DW-1:0]      wr_data,
    input logic               regs_clr,
    input logic [NREG*DW-1:0] regs
);
    logic [AW-1:0] a_q;
    logic [DW-1:0] picked;

    // Remember the last strobe address so the stored entry can be looked up.
    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= wr_addr;
    end

    // Select the register entry that a_q points at, or entry 0 when out of range.
    always_comb begin
        picked = regs[0 +: DW];
        for (int k = 0; k < NREG; k++)
            if (a_q == AW'(k)) picked = regs[k*DW +: DW];
    end

    AST_STB_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R4
    AST_STB_ENABLED:  assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> dev_en); // R4
    AST_EN_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(dev_en) |-> !wr_stb); // R2
    AST_CLR_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) regs_clr |=> !regs_clr); // R10
    AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n) regs_clr |-> !dev_en); // R10
    AST_CLR_EMPTIES:  assert property (@(posedge clk) disable iff (!rst_n) regs_clr |=> (regs == '0)); // R10
    AST_WRITE_LANDS:  assert property (@(posedge clk) disable iff (!rst_n)
                          (wr_stb && wr_addr < AW'(NREG)) |=> (picked == $past(wr_data))); // R11
endmodule

bind pcw_writer pcw_writer_chk #(.AW(AW), .DW(DW), .NREG(NREG)) chk_i (
    .clk(clk), .rst_n(rst_n), .dev_en(dev_en_o), .wr_stb(wr_stb_o),
    .wr_addr(wr_addr_o), .wr_data(wr_data_o), .regs_clr(regs_clr_o),
    .regs(regs_o)
);

// File: tb/pcw_writer_tb_top.sv
// Self-checking bench for pcw_writer with thresholds scaled down.
module pcw_writer_tb_top;
    localparam int NREG = 6;
    localparam int DW   = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               line = 1'b0;
    logic               dev_en, wr_stb, standby, regs_clr;
    logic [4:0]         wr_addr;
    logic [DW-1:0]      wr_data;
    logic [NREG*DW-1:0] regs;

    int n_chk = 0, n_err = 0;
    int stb_n = 0, clr_n = 0, last_a = -1, last_d = -1;
    int exp_r [NREG];

    always #4 clk = ~clk;

    pcw_writer #(
        .T_EN(40), .T_SD(120), .T_HOLD(20), .T_HOLDA_MAX(60),
        .T_STBY(100), .T_BR(150)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line), .dev_en_o(dev_en),
        .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .standby_o(standby), .regs_clr_o(regs_clr), .regs_o(regs)
    );

    // Vectors: {address value, data value}.
    localparam logic [10:0] VEC [7] = '{
        {5'd0, 6'd21}, {5'd5, 6'd63}, {5'd3, 6'd1}, {5'd1, 6'd40},
        {5'd9, 6'd7},  {5'd31, 6'd5}, {5'd2, 6'd0}
    };

    // Record strobes and clear pulses away from the active edge.
    always @(negedge clk) begin
        if (wr_stb) begin stb_n++; last_a = int'(wr_addr); last_d = int'(wr_data); end
        if (regs_clr) clr_n++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            line = 1'b0; repeat (3) @(negedge clk);
            line = 1'b1; repeat (3) @(negedge clk);
        end
    endtask

    task automatic stay(input int c);
        line = 1'b1; repeat (c) @(negedge clk);
    endtask

    task automatic pair(input int a, input int d);
        pulses(a + 1); stay(30); pulses(d + 1); stay(30);
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < NREG; k++) chk(req, int'(regs[k*DW +: DW]), exp_r[k]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int s0;
        for (int k = 0; k < NREG; k++) exp_r[k] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", int'(dev_en), 0);
        chk("R1 stb", int'(wr_stb), 0);
        chk("R1 standby", int'(standby), 0);
        chk("R1 clr", int'(regs_clr), 0);
        check_regs("R1 regs");

        // R2 short highs while disabled are ignored
        pulses(4); line = 1'b0; repeat (10) @(negedge clk);
        chk("R2 no enable", int'(dev_en), 0);
        chk("R2 no write", stb_n, 0);
        stay(50);
        chk("R2 enabled", int'(dev_en), 1);
        chk("R9 standby low", int'(standby), 0);

        // Vector walk: R3, R4, R11
        for (int i = 0; i < 7; i++) begin
            int a, d;
            a = int'(VEC[i][10:6]); d = int'(VEC[i][5:0]);
            s0 = stb_n;
            pair(a, d);
            chk("R4 one strobe", stb_n - s0, 1);
            chk("R3 address", last_a, a);
            chk("R4 data", last_d, d);
            if (a < NREG) exp_r[a] = d;
            check_regs("R11 regs");
        end

        // R3 hold with no pulses does nothing; following pair still lands
        s0 = stb_n; stay(40);
        chk("R3 empty hold", stb_n - s0, 0);
        pair(4, 33); exp_r[4] = 33;
        chk("R3 after empty", last_a, 4);
        check_regs("R3 regs");

        // R5 irregular gaps below T_HOLD accumulate into one count
        for (int i = 0; i < 3; i++) begin
            line = 1'b0; repeat (3) @(negedge clk);
            line = 1'b1; repeat (15) @(negedge clk);
        end
        stay(30); pulses(12); stay(30);
        chk("R5 address", last_a, 2);
        chk("R5 data", last_d, 11);
        exp_r[2] = 11;

        // R6 too-long address hold drops the address
        s0 = stb_n;
        pulses(3); stay(80);
        pulses(5); stay(30); pulses(10); stay(30);
        chk("R6 one strobe", stb_n - s0, 1);
        chk("R6 address", last_a, 4);
        chk("R6 data", last_d, 9);
        exp_r[4] = 9;

        // R7 address above 31 locks until bus reset
        s0 = stb_n;
        pulses(33); stay(30); pulses(3); stay(30); pulses(2); stay(30);
        chk("R7 locked", stb_n - s0, 0);
        stay(160);
        pair(3, 17); exp_r[3] = 17;
        chk("R7 after reset", last_a, 3);
        chk("R7 data", last_d, 17);

        // R8 data above 63 discarded, next burst is address
        s0 = stb_n;
        pulses(3); stay(30); pulses(65); stay(30);
        chk("R8 no strobe", stb_n - s0, 0);
        pair(5, 12); exp_r[5] = 12;
        chk("R8 address", last_a, 5);
        chk("R8 data", last_d, 12);
        check_regs("R8 regs");

        // R9 standby after long high
        stay(110);
        chk("R9 standby", int'(standby), 1);

        // R10 shutdown clears everything
        s0 = clr_n;
        line = 1'b0; repeat (130) @(negedge clk);
        chk("R10 disabled", int'(dev_en), 0);
        chk("R10 clear pulse", clr_n - s0, 1);
        for (int k = 0; k < NREG; k++) exp_r[k] = 0;
        check_regs("R10 regs");
        chk("R10 standby off", int'(standby), 0);

        // R2 re-enable after shutdown and write again
        stay(50);
        chk("R2 re-enable", int'(dev_en), 1);
        pair(1, 2); exp_r[1] = 2;
        check_regs("R11 after re-enable");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule